// File: doc/BRIEF.md
# Dual-Channel Serial Attenuation Preset Controller

This block is the digital control core for two 5-bit binary-weighted step attenuators, each spanning 0 to 31 dB in 1 dB steps. A three-wire serial port (serial clock, serial data, active-low chip-select) loads a 56-bit frame. The frame carries four preset attenuation codes for each channel. The presets only take effect when chip-select is released after exactly 56 bits.

In serial mode, each channel has two select pins. These pins pick one of its four stored presets on every system clock, with no further bus traffic. In parallel mode, each channel's 5-bit direct bus drives the attenuator code instead, and the stored presets are kept. The serial pins are asynchronous to the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain. The select, mode and parallel pins are taken as synchronous to the system clock. Each attenuation output is registered and follows its inputs one clock later.

Top module: `atten_state_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, both attenuation outputs, frame_err and rsvd_warn are 0 after that edge. All stored presets also clear to 0, meaning minimum attenuation.
- R2: With ser_csn low, ser_data is sampled on each rising ser_clk edge, MSB first, to form frame bits D55 down to D0. Channel 1 presets 1 to 4 come from D[12:8], D[17:13], D[22:18] and D[27:23]. Channel 2 presets 1 to 4 come from D[40:36], D[45:41], D[50:46] and D[55:51]. In each field the lowest bit is the 1 dB step.
- R3: The stored presets, and therefore the outputs in serial mode, do not change while a frame is being shifted. They change only after ser_csn rises.
- R4: In serial mode, select pins (A,B) = (0,0), (1,0), (0,1), (1,1) choose presets 1, 2, 3 and 4 of that channel respectively. The two channels select independently.
- R5: With serial_mode = 0, each channel's output equals its 5-bit parallel input one clock later. With serial_mode = 1, it shows the selected preset. Switching to parallel mode does not disturb the stored presets.
- R6: If ser_csn rises after a bit count other than 56 (fewer, or more), the stored presets are left unchanged and frame_err is high for exactly one clock.
- R7: Nonzero values in the reserved bits D[7:0] and D[35:28] of a complete frame have no effect on the presets. They set rsvd_warn, which stays set until reset.
- R8: Rising ser_clk edges while ser_csn is high shift nothing and do not count towards the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_csn | input | 1 | Serial chip-select, active low, asynchronous |
| serial_mode | input | 1 | 1: stored presets drive outputs; 0: parallel buses drive outputs |
| ch1_sel_a | input | 1 | Channel 1 preset select, low bit |
| ch1_sel_b | input | 1 | Channel 1 preset select, high bit |
| ch2_sel_a | input | 1 | Channel 2 preset select, low bit |
| ch2_sel_b | input | 1 | Channel 2 preset select, high bit |
| ch1_par | input | 5 | Channel 1 direct attenuation code |
| ch2_par | input | 5 | Channel 2 direct attenuation code |
| ch1_atten | output | 5 | Channel 1 attenuation code, 1 dB per LSB |
| ch2_atten | output | 5 | Channel 2 attenuation code, 1 dB per LSB |
| frame_err | output | 1 | One-clock pulse on a frame of the wrong length |
| rsvd_warn | output | 1 | Sticky flag: a complete frame had nonzero reserved bits |

## Verification
The assertions assume that serial_mode, the select pins and the parallel buses change only in step with clk. They also assume that each level of ser_clk and ser_csn lasts long enough for the synchronisers to see every edge. The stimulus therefore drives all pins just after a falling clk edge and holds every serial phase for four system clocks. The one-clock width of frame_err and the unchanged presets on a bad frame are checked against frames of 30 and 57 bits. The rule that presets hold while shifting is checked by reading the outputs in the middle of a frame.

// File: rtl/atten_pkg.sv
// Package: shared sizes and frame layout for the attenuation preset controller.
// Assumes two channels, each with a block of reserved bits followed by
// four presets, stacked from the frame LSB upwards.
package atten_pkg;
    localparam int ATT_W      = 5;                          // attenuation code width
    localparam int N_PRESET   = 4;                          // presets per channel
    localparam int N_CH       = 2;                          // channels
    localparam int RSV_W      = 8;                          // reserved bits per channel block
    localparam int CH_BITS    = RSV_W + N_PRESET * ATT_W;   // bits per channel block
    localparam int FRAME_BITS = N_CH * CH_BITS;             // whole frame
    localparam int SEL_W      = $clog2(N_PRESET);
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CNT_SAT    = FRAME_BITS + 1;             // count saturates past a full frame

    typedef logic [ATT_W-1:0]      att_t;
    typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/atten_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes every input level is held for longer than STAGES+1 clocks.
// Each bit resets to its idle value, given by RST_VAL.
module atten_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg [STAGES];

    // First stage: capture the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stages: let metastability settle.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/atten_frame_rx.sv
// Module: serial frame receiver. It detects serial clock and chip-select
// edges on the synchronised pins, shifts data MSB first while chip-select is
// low, and counts bits. On a chip-select rise it either publishes the frame
// with a one-cycle load strobe, or it pulses frame_err when the count is
// wrong. It also keeps a sticky flag for nonzero reserved bits.
// Assumes inputs are already synchronous to clk.
module atten_frame_rx
    import atten_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk_s,
    input  logic   sdata_s,
    input  logic   csn_s,
    output logic   load,
    output frame_t frame_q,
    output logic   frame_err,
    output logic   rsvd_warn
);
    logic             sclk_d, csn_d;
    logic             sclk_rise, cs_rise;
    frame_t           shreg;
    logic [CNT_W-1:0] cnt;
    logic             rsv_any;

    // Delay the synchronised levels by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = csn_s & ~csn_d;

    // OR together the reserved bits of every channel block.
    always_comb begin
        rsv_any = 1'b0;
        for (int c = 0; c < N_CH; c++)
            rsv_any = rsv_any | (|shreg[c*CH_BITS +: RSV_W]);
    end

    // Shift, count, and close the frame on the chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            load      <= 1'b0;
            frame_q   <= '0;
            frame_err <= 1'b0;
            rsvd_warn <= 1'b0;
        end else begin
            load      <= 1'b0;
            frame_err <= 1'b0;
            if (cs_rise) begin
                cnt <= '0;
                if (cnt == CNT_W'(FRAME_BITS)) begin
                    load    <= 1'b1;
                    frame_q <= shreg;
                    if (rsv_any) rsvd_warn <= 1'b1;
                end else begin
                    frame_err <= 1'b1;
                end
            end else if (!csn_s && sclk_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdata_s};
                if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: a length error lasts exactly one clock.
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6: a bad frame never publishes a load in the same cycle.
    p_err_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !load);

    // R7: the reserved-bit warning is sticky.
    p_warn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_warn |=> rsvd_warn);

    // R3: the published frame moves only with a load strobe.
    p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(frame_q));
endmodule

// File: rtl/atten_preset_bank.sv
// Module: one channel's preset storage and output selection. It stores four
// presets from its slice of the frame on a load strobe. Each clock it
// registers either the preset picked by {sel_b, sel_a}, or the parallel code.
// Assumes sel, mode and par are synchronous to clk.
module atten_preset_bank
    import atten_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CH_BITS-1:0] ch_bits,
    input  logic               serial_mode,
    input  logic               sel_a,
    input  logic               sel_b,
    input  att_t               par,
    output att_t               att_q
);
    logic [N_PRESET-1:0][ATT_W-1:0] pre_q;
    logic [SEL_W-1:0]               idx;

    assign idx = {sel_b, sel_a};

    for (genvar p = 0; p < N_PRESET; p++) begin : g_pre
        // Store one preset field when a complete frame arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)    pre_q[p] <= '0;
            else if (load) pre_q[p] <= ch_bits[RSV_W + p*ATT_W +: ATT_W];
        end
    end

    // Register the output code from the active source.
    always_ff @(posedge clk) begin
        if (!rst_n)           att_q <= '0;
        else if (serial_mode) att_q <= pre_q[idx];
        else                  att_q <= par;
    end

    // R3: presets hold unless a frame is published.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pre_q));

    // R5: parallel mode passes the bus through with one clock of delay.
    p_par_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |=> (att_q == $past(par)));
endmodule

// File: rtl/atten_state_ctrl.sv
// Module: top of the dual-channel attenuation preset controller. It
// synchronises the serial pins, receives the 56-bit frame and drives one
// preset bank per channel. Assumes the serial pins are asynchronous, and the
// mode, select and parallel pins are synchronous to clk.
module atten_state_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_csn,
    input  logic             serial_mode,
    input  logic             ch1_sel_a,
    input  logic             ch1_sel_b,
    input  logic             ch2_sel_a,
    input  logic             ch2_sel_b,
    input  logic [ATT_W-1:0] ch1_par,
    input  logic [ATT_W-1:0] ch2_par,
    output logic [ATT_W-1:0] ch1_atten,
    output logic [ATT_W-1:0] ch2_atten,
    output logic             frame_err,
    output logic             rsvd_warn
);
    logic [2:0]        pins_s;
    logic              load;
    frame_t            frame_q;
    logic [N_CH-1:0]   sel_a, sel_b;
    att_t              par  [N_CH];
    att_t              att  [N_CH];

    atten_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_csn, ser_data, ser_clk}),
        .d_sync  (pins_s)
    );

    atten_frame_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .sdata_s   (pins_s[1]),
        .csn_s     (pins_s[2]),
        .load      (load),
        .frame_q   (frame_q),
        .frame_err (frame_err),
        .rsvd_warn (rsvd_warn)
    );

    assign sel_a  = {ch2_sel_a, ch1_sel_a};
    assign sel_b  = {ch2_sel_b, ch1_sel_b};
    assign par[0] = ch1_par;
    assign par[1] = ch2_par;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        atten_preset_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (load),
            .ch_bits     (frame_q[c*CH_BITS +: CH_BITS]),
            .serial_mode (serial_mode),
            .sel_a       (sel_a[c]),
            .sel_b       (sel_b[c]),
            .par         (par[c]),
            .att_q       (att[c])
        );
    end

    assign ch1_atten = att[0];
    assign ch2_atten = att[1];

    // R1: reset clears outputs and flags.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ch1_atten == '0 && ch2_atten == '0 && !frame_err && !rsvd_warn));
endmodule

// File: tb/atten_state_ctrl_bench.sv
module atten_state_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_csn = 1'b1;
    logic       serial_mode = 1'b1;
    logic       ch1_sel_a = 1'b0, ch1_sel_b = 1'b0, ch2_sel_a = 1'b0, ch2_sel_b = 1'b0;
    logic [4:0] ch1_par = '0, ch2_par = '0;
    logic [4:0] ch1_atten, ch2_atten;
    logic       frame_err, rsvd_warn;

    int n_checks = 0;
    int n_errors = 0;
    int err_cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    atten_state_ctrl u_atten_state_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_csn(ser_csn),
        .serial_mode(serial_mode),
        .ch1_sel_a(ch1_sel_a), .ch1_sel_b(ch1_sel_b),
        .ch2_sel_a(ch2_sel_a), .ch2_sel_b(ch2_sel_b),
        .ch1_par(ch1_par), .ch2_par(ch2_par),
        .ch1_atten(ch1_atten), .ch2_atten(ch2_atten),
        .frame_err(frame_err), .rsvd_warn(rsvd_warn)
    );

    // Count the clocks on which the length-error pulse is high.
    always @(negedge clk) if (rst_n && frame_err === 1'b1) err_cycles++;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame layout per R2 and R7: reserved at [7:0]/[35:28], presets of 5 bits above.
    function automatic logic [55:0] mk(input logic [4:0] a0, a1, a2, a3,
                                       input logic [4:0] b0, b1, b2, b3,
                                       input logic [7:0] r1, r2);
        return {b3, b2, b1, b0, r2, a3, a2, a1, a0, r1};
    endfunction

    task automatic send_bit(input logic b);
        ser_data = b; ser_clk = 1'b0; idle(4);
        ser_clk = 1'b1; idle(4);
        ser_clk = 1'b0;
    endtask

    // Send the top nbits of w, MSB first, then release chip-select.
    task automatic send_frame(input logic [55:0] w, input int nbits);
        ser_csn = 1'b0; idle(4);
        for (int i = 0; i < nbits; i++) send_bit(i < 56 ? w[55-i] : 1'b0);
        idle(4); ser_csn = 1'b1; idle(10);
    endtask

    task automatic set_sel(input int s1, input int s2);
        ch1_sel_a = s1[0]; ch1_sel_b = s1[1];
        ch2_sel_a = s2[0]; ch2_sel_b = s2[1];
        idle(2);
    endtask

    task automatic t_reset();
        check("R1 ch1 after reset", ch1_atten, 0);
        check("R1 ch2 after reset", ch2_atten, 0);
        check("R1 frame_err after reset", frame_err, 0);
        check("R1 rsvd_warn after reset", rsvd_warn, 0);
        set_sel(3, 2);
        check("R1 ch1 preset4 cleared", ch1_atten, 0);
        check("R1 ch2 preset3 cleared", ch2_atten, 0);
    endtask

    // R2 field placement and R4 select decode.
    task automatic t_load_select();
        int e1 [4] = '{3, 17, 9, 30};
        int e2 [4] = '{31, 1, 22, 6};
        send_frame(mk(5'd3, 5'd17, 5'd9, 5'd30, 5'd31, 5'd1, 5'd22, 5'd6, 8'h00, 8'h00), 56);
        for (int s = 0; s < 4; s++) begin
            set_sel(s, 3 - s);
            check("R2/R4 ch1 preset", ch1_atten, e1[s]);
            check("R2/R4 ch2 preset", ch2_atten, e2[3 - s]);
        end
        check("R7 no warn on clean frame", rsvd_warn, 0);
    endtask

    // R3: outputs hold mid-frame and change only after chip-select rises.
    task automatic t_hold_shift();
        logic [55:0] w;
        w = mk(5'd10, 5'd11, 5'd12, 5'd13, 5'd20, 5'd21, 5'd22, 5'd23, 8'h00, 8'h00);
        set_sel(1, 2);
        ser_csn = 1'b0; idle(4);
        for (int i = 0; i < 56; i++) begin
            send_bit(w[55-i]);
            if (i == 40) begin
                check("R3 ch1 holds while shifting", ch1_atten, 17);
                check("R3 ch2 holds while shifting", ch2_atten, 22);
            end
        end
        idle(6);
        check("R3 ch1 holds before cs rise", ch1_atten, 17);
        ser_csn = 1'b1; idle(10);
        check("R3 ch1 updated after cs rise", ch1_atten, 11);
        check("R3 ch2 updated after cs rise", ch2_atten, 22);
    endtask

    // R5: parallel mode passthrough; presets survive.
    task automatic t_parallel();
        set_sel(0, 0);
        serial_mode = 1'b0; ch1_par = 5'd7; ch2_par = 5'd25; idle(2);
        check("R5 ch1 parallel", ch1_atten, 7);
        check("R5 ch2 parallel", ch2_atten, 25);
        ch1_par = 5'd31; ch2_par = 5'd0; idle(1);
        check("R5 ch1 parallel next clock", ch1_atten, 31);
        check("R5 ch2 parallel next clock", ch2_atten, 0);
        serial_mode = 1'b1; idle(2);
        check("R5 ch1 back to preset", ch1_atten, 10);
        check("R5 ch2 back to preset", ch2_atten, 20);
    endtask

    // R6: short and long frames leave presets, pulse error one clock each.
    task automatic t_bad_len();
        int base;
        base = err_cycles;
        send_frame(mk(5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 8'h00, 8'h00), 30);
        check("R6 short frame one-clock error", err_cycles - base, 1);
        check("R6 ch1 unchanged after short", ch1_atten, 10);
        send_frame(mk(5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 8'h00, 8'h00), 57);
        check("R6 long frame one-clock error", err_cycles - base, 2);
        check("R6 ch2 unchanged after long", ch2_atten, 20);
        set_sel(3, 3);
        check("R6 ch1 preset4 unchanged", ch1_atten, 13);
        check("R6 ch2 preset4 unchanged", ch2_atten, 23);
        check("R6 no warn from bad frames", rsvd_warn, 0);
    endtask

    // R8: serial clocks with chip-select high are ignored.
    task automatic t_cs_high();
        int base;
        base = err_cycles;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        idle(4);
        check("R8 ch1 unchanged", ch1_atten, 13);
        send_frame(mk(5'd4, 5'd5, 5'd6, 5'd8, 5'd16, 5'd15, 5'd14, 5'd0, 8'h00, 8'h00), 56);
        check("R8 following frame accepted", err_cycles - base, 0);
        check("R8 ch1 new preset4", ch1_atten, 8);
        check("R8 ch2 new preset4", ch2_atten, 0);
    endtask

    // R7: reserved bits ignored for outputs; warning is sticky.
    task automatic t_reserved();
        send_frame(mk(5'd0, 5'd31, 5'd18, 5'd5, 5'd9, 5'd27, 5'd3, 5'd12, 8'hA5, 8'h00), 56);
        check("R7 warn set", rsvd_warn, 1);
        set_sel(1, 3);
        check("R7 ch1 preset2 unaffected", ch1_atten, 31);
        check("R7 ch2 preset4 unaffected", ch2_atten, 12);
        send_frame(mk(5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 8'h00, 8'h80), 56);
        set_sel(0, 0);
        check("R7 ch1 loaded with ch2 reserved set", ch1_atten, 1);
        check("R7 ch2 loaded with ch2 reserved set", ch2_atten, 5);
        send_frame(mk(5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 8'h00, 8'h00), 56);
        check("R7 warn sticky after clean frame", rsvd_warn, 1);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1; idle(2);
        t_reset();
        t_load_select();
        t_hold_shift();
        t_parallel();
        t_bad_len();
        t_cs_high();
        t_reserved();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule